// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block lets synchronous logic reach an external asynchronous static RAM of 256K words by 16 bits. The user side posts one request at a time: a word address, write data, a per-byte enable, and a write/read select. It holds the request until a one-clock acknowledge comes back. For reads, the returned data is held stable from the acknowledge onward.

On the memory side the controller drives an active-low chip enable, write enable and output enable, plus one active-low strobe per byte lane. It also drives the address and a data bus that is split into out, in and drive-enable signals. Every phase length is a whole number of clocks. Each one is derived from the clock period in picoseconds and the memory's nanosecond limits. A write runs in four steps: an address phase with every strobe high, a write-enable-controlled pulse, and a recovery phase with write enable high, followed by an idle clock that carries the acknowledge. A read runs in three steps: an address phase, an access phase, and a capture.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, chip enable, write enable, output enable and all lane strobes read 1, the data drivers are off, acknowledge is 0 and the read data is 0.
- R2: Byte-enable bit 0 selects data bits 7..0 and lane strobe bit 0; bit 1 selects bits 15..8 and strobe bit 1. A lane whose enable bit is 0 keeps its strobe at 1 for the whole access, so its stored byte is left unchanged by a write.
- R3: The address never changes in a clock in which chip enable, write enable or any lane strobe was already low and is still low. During an access the address equals the requested address.
- R4: Write enable is low for exactly PULSE_CYC consecutive clocks per write, where PULSE_CYC = max(1, ceil(max(6500, 5000) / CLK_PS)). The request data is on the bus for that whole pulse.
- R5: Output enable stays 1 while write enable is 0. The data drivers are on only while write enable is 0 and output enable is 1.
- R6: During a read, write enable stays 1 while chip enable, output enable and the enabled lane strobes are 0. The returned lanes that were not enabled read as 0.
- R7: Acknowledge is high for one clock only. Counting clock edges from the edge that accepts the request, it rises after 1 + PULSE_CYC + RECOV_CYC edges for a write and after 1 + ACC_CYC edges for a read. Here RECOV_CYC = 1 and ACC_CYC = max(1, ceil(8000 / CLK_PS)).
- R8: A request is accepted only while the controller is idle and not in its acknowledge clock. Between two accesses there is at least one clock with every strobe and enable at 1, even when the request stays high.
- R9: Read data is what the memory returned in the last access clock, and it is stored byte for byte by the writes that came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request valid, held until ack |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqByteEn | input | 2 | Per-lane enable, bit 0 = low byte |
| ack | output | 1 | One-clock completion pulse |
| rdData | output | 16 | Registered read data |
| memAddr | output | 18 | Memory address |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memLaneN | output | 2 | Byte strobes, active low, bit 0 = low byte |
| memDqOut | output | 16 | Data driven toward memory |
| memDqIn | input | 16 | Data returned from memory |
| memDqOe | output | 1 | Drive enable for memDqOut |

## Verification
The sequencer state appears directly on the registered control pins, so a wrong state shows up at the memory port in the same clock. It can show as a strobe low outside its phase, a pulse one clock too short or too long, or the drivers on while output enable is low. An error in the datapath's lane register or capture shows up in memory contents or read data. That error appears at the first read-back that follows a masked write, and the unselected lanes are driven with a junk byte so that a capture through the wrong lane cannot hide. Latency errors appear as an acknowledge on the wrong edge of the very first access.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PULSE,
    ST_RECOV,
    ST_ACCESS
  } seqState_t;

  // per-clock control requests from sequencer to datapath
  typedef struct packed {
    logic load;     // register user request
    logic chipOn;   // chip enable asserted next clock
    logic writeOn;  // write enable asserted next clock
    logic outOn;    // output enable asserted next clock
    logic laneOn;   // enabled lanes asserted next clock
    logic driveOn;  // own data drivers on next clock
    logic capture;  // sample returned data at this edge
  } pinCtl_t;

  // clocks needed to cover a limit, never fewer than one
  function automatic int cyclesFor(input int limitPs, input int clkPs);
    int n;
    n = (limitPs + clkPs - 1) / clkPs;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/sram_port_seq.sv
module sram_port_seq
  import sram_port_pkg::*;
#(
  parameter int CLK_PS  = 10000,
  parameter int WP_PS   = 6500,
  parameter int DW_PS   = 5000,
  parameter int WR_PS   = 0,
  parameter int ACC_PS  = 8000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    reqWrite,
  output pinCtl_t ctl,
  output logic    ack
);

  localparam int PULSE_LIM = (WP_PS > DW_PS) ? WP_PS : DW_PS;
  localparam int PULSE_CYC = cyclesFor(PULSE_LIM, CLK_PS);
  localparam int RECOV_CYC = cyclesFor(WR_PS, CLK_PS);
  localparam int ACC_CYC   = cyclesFor(ACC_PS, CLK_PS);
  localparam int MAX_A     = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
  localparam int MAX_CYC   = (MAX_A > ACC_CYC) ? MAX_A : ACC_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seqState_t  state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic       isWrite;
  logic       pulseLast, recovLast, accLast;
  logic       accept, finish;

  assign pulseLast = (cnt == CNT_W'(PULSE_CYC - 1));
  assign recovLast = (cnt == CNT_W'(RECOV_CYC - 1));
  assign accLast   = (cnt == CNT_W'(ACC_CYC - 1));
  assign accept    = (state == ST_IDLE) && req && !ack;

  always_comb begin
    stateNext = state;
    finish    = 1'b0;
    unique case (state)
      ST_IDLE:   if (accept) stateNext = ST_ADDR;
      ST_ADDR:   stateNext = isWrite ? ST_PULSE : ST_ACCESS;
      ST_PULSE:  if (pulseLast) stateNext = ST_RECOV;
      ST_RECOV:  if (recovLast) begin
                   stateNext = ST_IDLE;
                   finish    = 1'b1;
                 end
      ST_ACCESS: if (accLast) begin
                   stateNext = ST_IDLE;
                   finish    = 1'b1;
                 end
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = accept;
    ctl.chipOn  = (stateNext == ST_PULSE) || (stateNext == ST_RECOV) ||
                  (stateNext == ST_ACCESS);
    ctl.laneOn  = ctl.chipOn;
    ctl.writeOn = (stateNext == ST_PULSE);
    ctl.driveOn = (stateNext == ST_PULSE);
    ctl.outOn   = (stateNext == ST_ACCESS);
    ctl.capture = (state == ST_ACCESS) && accLast;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      ack     <= 1'b0;
    end else begin
      state <= stateNext;
      ack   <= finish;
      if (accept) isWrite <= reqWrite;
      if (stateNext != state) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sram_port_dp.sv
module sram_port_dp
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pinCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqByteEn,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memLaneN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  laneQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ   <= '0;
      dataQ   <= '0;
      laneQ   <= '0;
      memCeN  <= 1'b1;
      memWeN  <= 1'b1;
      memOeN  <= 1'b1;
      memDqOe <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
        laneQ <= reqByteEn;
      end
      memCeN  <= !ctl.chipOn;
      memWeN  <= !ctl.writeOn;
      memOeN  <= !ctl.outOn;
      memDqOe <= ctl.driveOn;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = dataQ;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        memLaneN[g] <= 1'b1;
        rdData[g*LANE_W +: LANE_W] <= '0;
      end else begin
        memLaneN[g] <= !(ctl.laneOn && laneQ[g]);
        if (ctl.capture)
          rdData[g*LANE_W +: LANE_W] <= laneQ[g] ? memDqIn[g*LANE_W +: LANE_W]
                                                 : '0;
      end
    end
  end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int CLK_PS = 10000,
  parameter int WP_PS  = 6500,
  parameter int DW_PS  = 5000,
  parameter int WR_PS  = 0,
  parameter int ACC_PS = 8000,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqByteEn,
  output logic              ack,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memLaneN,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);

  pinCtl_t ctl;

  sram_port_seq #(
    .CLK_PS(CLK_PS), .WP_PS(WP_PS), .DW_PS(DW_PS),
    .WR_PS(WR_PS), .ACC_PS(ACC_PS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .reqWrite(reqWrite),
    .ctl(ctl), .ack(ack)
  );

  sram_port_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(8)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .memDqIn(memDqIn), .memAddr(memAddr), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .memLaneN(memLaneN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .rdData(rdData)
  );

endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic [LANES-1:0]  memLaneN,
  input logic              memDqOe
);

  logic active;
  assign active = !memCeN || !memWeN || !(&memLaneN);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && active) |-> $stable(memAddr));

  assert_oe_off_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !memWeN |-> memOeN);

  assert_drive_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    memDqOe |-> (!memWeN && memOeN));

  assert_read_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !memOeN |-> (memWeN && !memCeN));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_ack_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (memCeN && memWeN && memOeN && (&memLaneN)));

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .memAddr(memAddr), .memCeN(memCeN),
  .memWeN(memWeN), .memOeN(memOeN), .memLaneN(memLaneN), .memDqOe(memDqOe)
);

// File: tb/sram_port_ctrl_tb.sv
`timescale 1ns/1ps
module sram_port_ctrl_tb;

  localparam int CLK_NS   = 10;
  localparam int CLK_PS   = CLK_NS * 1000;
  localparam int PULSE_RAW = (6500 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_WP   = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
  localparam int ACC_RAW  = (8000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_ACC  = (ACC_RAW < 1) ? 1 : ACC_RAW;
  localparam int EXP_REC  = 1;
  // negedges counted from request drive to ack visible
  localparam int LAT_W    = 2 + EXP_WP + EXP_REC;
  localparam int LAT_R    = 2 + EXP_ACC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqByteEn = '0;
  logic ack;
  logic [15:0] rdData;
  logic [17:0] memAddr;
  logic memCeN, memWeN, memOeN, memDqOe;
  logic [1:0] memLaneN;
  logic [15:0] memDqOut, memDqIn;

  int nTests = 0, nFail = 0;
  logic [15:0] memArr [256];

  always #(CLK_NS/2.0) clk = ~clk;

  sram_port_ctrl #(.CLK_PS(CLK_PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .ack(ack), .rdData(rdData), .memAddr(memAddr), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .memLaneN(memLaneN),
    .memDqOut(memDqOut), .memDqIn(memDqIn), .memDqOe(memDqOe)
  );

  // memory model: unselected lanes return a junk byte
  always_comb begin
    for (int i = 0; i < 2; i++)
      memDqIn[i*8 +: 8] = (!memCeN && !memOeN && memWeN && !memLaneN[i])
                          ? memArr[memAddr[7:0]][i*8 +: 8] : 8'hEE;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // protocol monitor
  logic [17:0] prevAddr = '0;
  logic prevActive = 1'b0, prevQuiet = 1'b1, prevCeN = 1'b1;
  int pulseCnt = 0;
  logic [17:0] expAddr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic act = !memCeN || !memWeN || !(&memLaneN);
      if (prevActive && act && memAddr != prevAddr)
        check(0, "R3 addr moved", memAddr, prevAddr);
      if (act && memAddr != expAddr)
        check(0, "R3 addr mismatch", memAddr, expAddr);
      if (memDqOe && !(memOeN && !memWeN))
        check(0, "R5 drive overlap", memOeN, 1);
      if (!memWeN && !memOeN)
        check(0, "R5 oe in write", memOeN, 1);
      if (!memCeN && prevCeN && !prevQuiet)
        check(0, "R8 no quiet gap", 0, 1);
      if (!memWeN) begin
        pulseCnt++;
        if (!memDqOe) check(0, "R4 data not driven", memDqOe, 1);
        for (int i = 0; i < 2; i++)
          if (!memCeN && !memLaneN[i])
            memArr[memAddr[7:0]][i*8 +: 8] = memDqOut[i*8 +: 8];
      end else if (pulseCnt > 0) begin
        check(pulseCnt == EXP_WP, "R4 pulse length", pulseCnt, EXP_WP);
        pulseCnt = 0;
      end
      prevActive = act;
      prevAddr   = memAddr;
      prevCeN    = memCeN;
      prevQuiet  = memCeN && memWeN && memOeN && (&memLaneN);
    end
  end

  task automatic access(input bit w, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] r, output int lat);
    @(negedge clk);
    req = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d; reqByteEn = m;
    expAddr = a;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack && lat < 100);
    r = rdData;
    req = 1'b0;
    @(negedge clk);
    check(!ack, "R7 ack width", ack, 0);
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction

  initial begin
    #(CLK_NS * 150000);
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int lat;
    for (int i = 0; i < 256; i++) memArr[i] = 16'h0000;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(memCeN && memWeN && memOeN && (&memLaneN), "R1 pins idle",
          {memCeN, memWeN, memOeN, memLaneN}, 5'h1f);
    check(!memDqOe && !ack, "R1 drivers/ack", {memDqOe, ack}, 0);
    check(rdData == 16'h0, "R1 rdData", rdData, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep addresses and masks (R2, R4, R6, R7, R9)
    for (int ai = 0; ai < 8; ai++) begin
      for (int m = 0; m < 4; m++) begin
        automatic logic [17:0] a = 18'((ai * 37 + m * 5) & 8'hff) | (ai[0] ? 18'h20000 : 18'h0);
        automatic logic [15:0] base = 16'(16'h1234 * (ai + 1) + m);
        automatic logic [15:0] nw = ~base ^ 16'h5a5a;
        automatic logic [15:0] exp;
        access(1'b1, a, base, 2'b11, r, lat);
        check(lat == LAT_W, "R7 write latency", lat, LAT_W);
        access(1'b1, a, nw, 2'(m), r, lat);
        exp = merge(base, nw, 2'(m));
        access(1'b0, a, 16'h0, 2'b11, r, lat);
        check(lat == LAT_R, "R7 read latency", lat, LAT_R);
        check(r == exp, "R2 R9 masked write readback", r, exp);
        access(1'b0, a, 16'h0, 2'(m), r, lat);
        check(r == merge(16'h0, exp, 2'(m)), "R6 masked read lanes", r,
              merge(16'h0, exp, 2'(m)));
      end
    end

    // R8: request held high; period is latency plus one quiet clock
    begin
      int acks = 0;
      @(negedge clk);
      req = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00040; reqWdata = 16'hbeef;
      reqByteEn = 2'b11; expAddr = 18'h00040;
      for (int k = 0; k < 15; k++) begin
        @(negedge clk);
        if (ack) begin
          acks++;
          check(memCeN && (&memLaneN), "R8 quiet at ack", memCeN, 1);
        end
      end
      req = 1'b0;
      repeat (6) @(negedge clk);
      check(acks == (15 - LAT_W) / (LAT_W + 1) + 1, "R8 held request count",
            acks, (15 - LAT_W) / (LAT_W + 1) + 1);
      access(1'b0, 18'h00040, 16'h0, 2'b11, r, lat);
      check(r == 16'hbeef, "R9 held write data", r, 16'hbeef);
    end

    // R2: write with no lanes leaves memory unchanged and no strobe drops
    access(1'b1, 18'h00041, 16'h1111, 2'b11, r, lat);
    access(1'b1, 18'h00041, 16'h2222, 2'b00, r, lat);
    access(1'b0, 18'h00041, 16'h0, 2'b11, r, lat);
    check(r == 16'h1111, "R2 empty mask write", r, 16'h1111);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule